// File: doc/BRIEF.md
# EEPROM Page Write Pacer

This block writes one page of bytes into a parallel EEPROM that sits on a shared memory bus. A page starts with a start command that carries a byte count. For each byte, the block takes the byte from a page-buffer handshake and then asks a memory-bus arbiter for a single write cycle. The write address inside the page is the byte's index.

The EEPROM needs a long minimum time between write strobes, and the memory driver by itself would cycle far faster than that. The pacer therefore holds each byte back until two periodic microsecond ticks have passed since the previous bus write completed. While it waits it leaves the bus free, so other requesters get slots during a page. The device also starts committing the page to its cells if the gap between writes gets too long. A tick-based watchdog aborts the page and raises a sticky error when the gap reaches 30 ticks.

A busy output tells a status register that a page write is in progress. A programmable post-page delay, counted in ticks, stretches busy after the last byte.

Top module: `eeprom_page_pacer`

## Requirements
- R1: A start is accepted only while the block is idle and its count lies between 1 and 64 inclusive. A count of 0 or above 64, or any start while busy, has no effect: busy stays as it was and no extra bus write appears.
- R2: Busy rises on the clock after an accepted start. It falls on the first clock after the Nth tick that follows completion of the last byte's bus cycle, where N (at least 1 in use) is the post-delay sampled with the start.
- R3: An accepted page of C bytes produces exactly C bus grants. The offsets run 0, 1, ..., C-1 in order, and each carries the data bytes in the order they were handed in. Offset and data hold steady while the request is pending.
- R4: A bus request for any byte after the first is raised only after at least 2 ticks have been seen since the previous bus cycle completed. A tick in the same cycle as completion is not counted. The first byte of a page is not held back.
- R5: Once raised, the bus request stays high until it is granted, and it is low on the clock after a grant. The bus is never requested while the block waits between bytes.
- R6: Consider the bytes after the first. If 30 ticks accumulate since the previous completion while the block is still waiting for a byte, a pacing slot or a grant, the page is aborted: error rises while busy and request fall, on the first clock after the 30th tick.
- R7: The error flag stays set until the next accepted start clears it. Rejected starts do not clear it.
- R8: A synchronous abort input returns the block to idle on the next clock from any state. Busy, request and byte-ready are then low and the error flag is left unchanged. A later start works normally.
- R9: Byte-ready is high only while the block waits for the next byte. It is never high together with the bus request. No bus request is made before the byte for that write has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_i | input | 1 | Synchronous abort to idle |
| start_i | input | 1 | Start a page write |
| start_count_i | input | 7 | Bytes in the page (1..64 valid) |
| post_delay_i | input | 8 | Ticks busy stays high after the last byte |
| tick_i | input | 1 | One-cycle strobe, once per microsecond |
| byte_valid_i | input | 1 | Page-buffer byte available |
| byte_data_i | input | 8 | Page-buffer byte |
| byte_ready_o | output | 1 | Block takes the byte this cycle |
| bus_req_o | output | 1 | Memory-bus write request |
| bus_gnt_i | input | 1 | Arbiter grant, one cycle |
| bus_done_i | input | 1 | Granted bus cycle completed, one cycle |
| bus_offset_o | output | 6 | Byte index within the page |
| bus_data_o | output | 8 | Byte to write |
| busy_o | output | 1 | Page write in progress |
| error_o | output | 1 | Sticky page-commit gap error |

## Verification
The assertions assume a well-behaved arbiter and timebase. A grant arrives only while the request is high, completion comes only after a grant and before the next request, and a tick is a single-cycle strobe. Under those assumptions, the checker's own tick count since the last completion mirrors the block's view of the gap. The bench's bus model keeps within these limits. It grants only an observed request, sends completion a fixed few cycles after each grant, and is cleared on abort so that no completion is left over. Ticks come every 50 clocks, so no tick falls on the clock where a post-delay or watchdog decision is taken.

// File: rtl/eeprom_pacer_pkg.sv
// Package: shared state encoding for the EEPROM page write pacer.
// Assumes nothing beyond being compiled before the modules that import it.
package eeprom_pacer_pkg;

    // Sequencer states, one page write walks FETCH..XFER once per byte.
    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_FETCH = 3'd1,
        PS_PACE  = 3'd2,
        PS_REQ   = 3'd3,
        PS_XFER  = 3'd4,
        PS_POST  = 3'd5
    } pacer_state_e;

endpackage

// File: rtl/pacer_gap_timer.sv
// Gap timer: counts timebase ticks since the last completed bus write,
// saturating at MAX_GAP. Reports when the minimum spacing is met and when
// the page-commit window has been used up.
// Assumes tick_i is a single-cycle strobe; clear_i has priority over a tick.
module pacer_gap_timer #(
    parameter int MIN_GAP = 2,
    parameter int MAX_GAP = 30,
    localparam int GAP_W  = $clog2(MAX_GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic gap_met_o,
    output logic gap_expired_o
);

    logic [GAP_W-1:0] gap_q;

    // Tick counter since last write completion, saturating at the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (clear_i) begin
            gap_q <= '0;
        end else if (tick_i && (gap_q != GAP_W'(MAX_GAP))) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // Minimum-spacing flag; a zero spacing needs no comparator.
    generate
        if (MIN_GAP == 0) begin : g_no_min
            assign gap_met_o = 1'b1;
        end else begin : g_min
            assign gap_met_o = (gap_q >= GAP_W'(MIN_GAP));
        end
    endgenerate

    // Window-used-up flag for the watchdog.
    assign gap_expired_o = (gap_q == GAP_W'(MAX_GAP));

endmodule

// File: rtl/pacer_post_timer.sv
// Post-page timer: while run_i is high, counts ticks and flags when the
// programmed number has been reached. Clears itself whenever run_i is low.
// Assumes limit_i is held stable while run_i is high.
module pacer_post_timer #(
    parameter int POST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [POST_W-1:0] limit_i,
    output logic              done_o
);

    logic [POST_W-1:0] cnt_q;

    // Tick count inside the post-page phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != limit_i)) begin
            cnt_q <= cnt_q + POST_W'(1);
        end
    end

    // Phase finished once the programmed tick count has been seen.
    assign done_o = run_i && (cnt_q == limit_i);

endmodule

// File: rtl/pacer_fsm.sv
// Page sequencer: accepts a page start, takes one byte at a time, waits for
// the pacing slot, requests the bus, waits for completion, and finishes with
// the post-page phase. Owns the byte index, byte holding register, sticky
// error and the watchdog decision.
// Assumes bus_gnt_i only while bus_req_o is high and bus_done_i only after
// a grant; abort_i has priority over every other event.
module pacer_fsm
    import eeprom_pacer_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int POST_W     = 8,
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1),
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  start_count_i,
    input  logic [POST_W-1:0] post_delay_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              bus_gnt_i,
    input  logic              bus_done_i,
    input  logic              gap_met_i,
    input  logic              gap_expired_i,
    input  logic              post_done_i,
    output logic              gap_clear_o,
    output logic              post_run_o,
    output logic [POST_W-1:0] post_limit_o,
    output logic              byte_ready_o,
    output logic              bus_req_o,
    output logic [IDX_W-1:0]  bus_offset_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              busy_o,
    output logic              error_o
);

    pacer_state_e      state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx_q;
    logic [DATA_W-1:0] data_q;
    logic [POST_W-1:0] post_q;
    logic              first_q;
    logic              err_q;

    logic count_ok;
    logic accept;
    logic waiting;
    logic wd_trip;
    logic take_byte;
    logic wr_done;
    logic last_byte;

    // Start qualification: count must be 1..PAGE_BYTES and block idle.
    assign count_ok  = (start_count_i != '0) && (start_count_i <= CNT_W'(PAGE_BYTES));
    assign accept    = (state_q == PS_IDLE) && start_i && count_ok && !abort_i;

    // Watchdog applies to inter-byte waiting after the first write only.
    assign waiting   = (state_q == PS_FETCH) || (state_q == PS_PACE) || (state_q == PS_REQ);
    assign wd_trip   = waiting && !first_q && gap_expired_i && !abort_i;

    assign take_byte = (state_q == PS_FETCH) && byte_valid_i && !abort_i && !wd_trip;
    assign wr_done   = (state_q == PS_XFER) && bus_done_i && !abort_i;
    assign last_byte = (idx_q == last_idx_q);

    // Next-state decision; abort and watchdog override normal progress.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (accept)                    state_d = PS_FETCH;
            PS_FETCH: if (byte_valid_i)              state_d = PS_PACE;
            PS_PACE:  if (first_q || gap_met_i)      state_d = PS_REQ;
            PS_REQ:   if (bus_gnt_i)                 state_d = PS_XFER;
            PS_XFER:  if (bus_done_i)                state_d = last_byte ? PS_POST : PS_FETCH;
            PS_POST:  if (post_done_i)               state_d = PS_IDLE;
            default:                                 state_d = PS_IDLE;
        endcase
        if (wd_trip || abort_i) begin
            state_d = PS_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Page context captured at start: last index and post-delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx_q <= '0;
            post_q     <= '0;
        end else if (accept) begin
            last_idx_q <= IDX_W'(start_count_i - CNT_W'(1));
            post_q     <= post_delay_i;
        end
    end

    // Byte index and first-byte marker, advanced on each completed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            first_q <= 1'b0;
        end else if (accept) begin
            idx_q   <= '0;
            first_q <= 1'b1;
        end else if (wr_done) begin
            first_q <= 1'b0;
            if (!last_byte) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // Holding register for the byte being written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take_byte) begin
            data_q <= byte_data_i;
        end
    end

    // Sticky error: set by watchdog, cleared only by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (accept) begin
            err_q <= 1'b0;
        end else if (wd_trip) begin
            err_q <= 1'b1;
        end
    end

    assign gap_clear_o  = accept || wr_done;
    assign post_run_o   = (state_q == PS_POST);
    assign post_limit_o = post_q;
    assign byte_ready_o = (state_q == PS_FETCH);
    assign bus_req_o    = (state_q == PS_REQ);
    assign bus_offset_o = idx_q;
    assign bus_data_o   = data_q;
    assign busy_o       = (state_q != PS_IDLE);
    assign error_o      = err_q;

endmodule

// File: rtl/eeprom_page_pacer.sv
// EEPROM page write pacer top: joins the sequencer with the inter-write gap
// timer and the post-page timer.
// Assumes tick_i is a one-cycle strobe per microsecond and that the arbiter
// grants only a raised request and completes only a granted cycle.
module eeprom_page_pacer #(
    parameter int PAGE_BYTES    = 64,
    parameter int DATA_W        = 8,
    parameter int MIN_GAP_TICKS = 2,
    parameter int MAX_GAP_TICKS = 30,
    parameter int POST_W        = 8,
    localparam int CNT_W        = $clog2(PAGE_BYTES + 1),
    localparam int IDX_W        = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  start_count_i,
    input  logic [POST_W-1:0] post_delay_i,
    input  logic              tick_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_data_i,
    output logic              byte_ready_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    input  logic              bus_done_i,
    output logic [IDX_W-1:0]  bus_offset_o,
    output logic [DATA_W-1:0] bus_data_o,
    output logic              busy_o,
    output logic              error_o
);

    logic              gap_clear;
    logic              gap_met;
    logic              gap_expired;
    logic              post_run;
    logic              post_done;
    logic [POST_W-1:0] post_limit;

    pacer_gap_timer #(
        .MIN_GAP (MIN_GAP_TICKS),
        .MAX_GAP (MAX_GAP_TICKS)
    ) u_gap (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_i       (gap_clear),
        .tick_i        (tick_i),
        .gap_met_o     (gap_met),
        .gap_expired_o (gap_expired)
    );

    pacer_post_timer #(
        .POST_W (POST_W)
    ) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (post_run),
        .tick_i  (tick_i),
        .limit_i (post_limit),
        .done_o  (post_done)
    );

    pacer_fsm #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .POST_W     (POST_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .abort_i       (abort_i),
        .start_i       (start_i),
        .start_count_i (start_count_i),
        .post_delay_i  (post_delay_i),
        .byte_valid_i  (byte_valid_i),
        .byte_data_i   (byte_data_i),
        .bus_gnt_i     (bus_gnt_i),
        .bus_done_i    (bus_done_i),
        .gap_met_i     (gap_met),
        .gap_expired_i (gap_expired),
        .post_done_i   (post_done),
        .gap_clear_o   (gap_clear),
        .post_run_o    (post_run),
        .post_limit_o  (post_limit),
        .byte_ready_o  (byte_ready_o),
        .bus_req_o     (bus_req_o),
        .bus_offset_o  (bus_offset_o),
        .bus_data_o    (bus_data_o),
        .busy_o        (busy_o),
        .error_o       (error_o)
    );

endmodule

// File: rtl/eeprom_page_pacer_chk.sv
// Checker for the EEPROM page write pacer, bound into every instance.
// Keeps its own tick count since the last completed write and its own
// first-byte marker, derived from the ports only.
// Assumes grant only with a request and completion only after a grant.
module eeprom_page_pacer_chk #(
    parameter int PAGE_BYTES    = 64,
    parameter int DATA_W        = 8,
    parameter int MIN_GAP_TICKS = 2,
    parameter int MAX_GAP_TICKS = 30,
    localparam int CNT_W        = $clog2(PAGE_BYTES + 1),
    localparam int IDX_W        = $clog2(PAGE_BYTES),
    localparam int GAP_W        = $clog2(MAX_GAP_TICKS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort_i,
    input logic              start_i,
    input logic [CNT_W-1:0]  start_count_i,
    input logic              tick_i,
    input logic              bus_gnt_i,
    input logic              bus_done_i,
    input logic              byte_ready_o,
    input logic              bus_req_o,
    input logic [IDX_W-1:0]  bus_offset_o,
    input logic [DATA_W-1:0] bus_data_o,
    input logic              busy_o,
    input logic              error_o
);

    logic             good_count;
    logic             taken;
    logic [GAP_W-1:0] ck_gap;
    logic             ck_first;

    assign good_count = (start_count_i != '0) && (start_count_i <= CNT_W'(PAGE_BYTES));
    assign taken      = !busy_o && start_i && good_count && !abort_i;

    // Observed ticks since last completion, and first-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_gap   <= '0;
            ck_first <= 1'b0;
        end else begin
            if (taken || bus_done_i) begin
                ck_gap <= '0;
            end else if (tick_i && (ck_gap != GAP_W'(MAX_GAP_TICKS))) begin
                ck_gap <= ck_gap + GAP_W'(1);
            end
            if (taken) begin
                ck_first <= 1'b1;
            end else if (bus_done_i) begin
                ck_first <= 1'b0;
            end
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> busy_o);                                                       // R1
    AST_BAD_COUNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !good_count) |=> !busy_o);                        // R1
    AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && $past(bus_req_o)) |-> ($stable(bus_offset_o) && $stable(bus_data_o))); // R3
    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> (ck_first || (ck_gap >= GAP_W'(MIN_GAP_TICKS))));  // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_gnt_i && !abort_i && (ck_first || ck_gap != GAP_W'(MAX_GAP_TICKS)))
        |=> bus_req_o);                                                          // R5
    AST_REQ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_gnt_i) |=> !bus_req_o);                                // R5
    AST_REQ_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> busy_o);                                                   // R5
    AST_ERROR_DROPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> (!busy_o && !bus_req_o));                             // R6
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !taken) |=> error_o);                                        // R7
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !bus_req_o && !byte_ready_o));                   // R8
    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (busy_o && !bus_req_o));                                // R9

endmodule

bind eeprom_page_pacer eeprom_page_pacer_chk #(
    .PAGE_BYTES    (PAGE_BYTES),
    .DATA_W        (DATA_W),
    .MIN_GAP_TICKS (MIN_GAP_TICKS),
    .MAX_GAP_TICKS (MAX_GAP_TICKS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .abort_i       (abort_i),
    .start_i       (start_i),
    .start_count_i (start_count_i),
    .tick_i        (tick_i),
    .bus_gnt_i     (bus_gnt_i),
    .bus_done_i    (bus_done_i),
    .byte_ready_o  (byte_ready_o),
    .bus_req_o     (bus_req_o),
    .bus_offset_o  (bus_offset_o),
    .bus_data_o    (bus_data_o),
    .busy_o        (busy_o),
    .error_o       (error_o)
);

// File: tb/eeprom_page_pacer_tb.sv
// Scoreboard bench: driver tasks queue expected (offset, data) items and
// feed bytes; a bus model grants requests and a monitor compares each grant.
module eeprom_page_pacer_tb;

    localparam int TICK_DIV = 50;
    localparam int MIN_GAP  = 2;
    localparam int MAX_GAP  = 30;
    localparam int LIMIT    = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       abort_i = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] start_count_i = '0;
    logic [7:0] post_delay_i = '0;
    logic       tick_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       byte_ready_o;
    logic       bus_req_o;
    logic       bus_gnt_i = 1'b0;
    logic       bus_done_i = 1'b0;
    logic [5:0] bus_offset_o;
    logic [7:0] bus_data_o;
    logic       busy_o;
    logic       error_o;

    always #10 clk = ~clk;

    eeprom_page_pacer u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .abort_i       (abort_i),
        .start_i       (start_i),
        .start_count_i (start_count_i),
        .post_delay_i  (post_delay_i),
        .tick_i        (tick_i),
        .byte_valid_i  (byte_valid_i),
        .byte_data_i   (byte_data_i),
        .byte_ready_o  (byte_ready_o),
        .bus_req_o     (bus_req_o),
        .bus_gnt_i     (bus_gnt_i),
        .bus_done_i    (bus_done_i),
        .bus_offset_o  (bus_offset_o),
        .bus_data_o    (bus_data_o),
        .busy_o        (busy_o),
        .error_o       (error_o)
    );

    typedef struct {
        int off;
        int data;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] feed_q[$];

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          tb_gap = 0;
    int          grants = 0;
    int          gnt_delay = 0;
    int          slow_from = 1000;
    int          rsp = 0;
    int          rsp_wait = 0;
    int          cur_post = 0;
    bit          first_flag = 1'b0;
    bit          chk_post = 1'b0;
    bit          feed_en = 1'b1;
    logic        prev_busy = 1'b0;
    logic        prev_err = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bus model, tick source, byte feeder and grant monitor.
    always @(negedge clk) begin
        cyc++;
        if (bus_done_i) begin
            tb_gap = 0;
            first_flag = 1'b0;
        end else if (tick_i && tb_gap < MAX_GAP) begin
            tb_gap++;
        end
        if (prev_busy && !busy_o && chk_post && !error_o) begin
            chk(tb_gap == cur_post, "R2 busy fall after post ticks", tb_gap, cur_post);
            chk_post = 1'b0;
        end
        if (!prev_err && error_o) begin
            chk(tb_gap == MAX_GAP, "R6 error at gap limit", tb_gap, MAX_GAP);
            chk(!busy_o && !bus_req_o, "R6 page dropped", int'(busy_o) + int'(bus_req_o), 0);
        end
        if (byte_ready_o && bus_req_o) chk(1'b0, "R9 ready with request", 1, 0);
        tick_i = ((cyc % TICK_DIV) == 0);
        bus_gnt_i = 1'b0;
        bus_done_i = 1'b0;
        if (!rst_n || abort_i) begin
            rsp = 0;
        end else begin
            case (rsp)
                0: if (bus_req_o) begin
                    rsp = 1;
                    rsp_wait = (grants >= slow_from) ? 2500 : gnt_delay;
                end
                1: if (!bus_req_o) begin
                    rsp = 0;
                end else if (rsp_wait == 0) begin
                    bus_gnt_i = 1'b1;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected grant", int'(bus_offset_o), -1);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        chk(int'(bus_offset_o) == it.off, "R3 offset", int'(bus_offset_o), it.off);
                        chk(int'(bus_data_o) == it.data, "R3 data", int'(bus_data_o), it.data);
                    end
                    chk(first_flag || tb_gap >= MIN_GAP, "R4 spacing", tb_gap, MIN_GAP);
                    grants++;
                    rsp = 2;
                    rsp_wait = 3;
                end else begin
                    rsp_wait--;
                end
                default: if (rsp_wait == 0) begin
                    bus_done_i = 1'b1;
                    rsp = 0;
                end else begin
                    rsp_wait--;
                end
            endcase
        end
        byte_valid_i = feed_en && (feed_q.size() > 0);
        byte_data_i  = byte_valid_i ? feed_q[0] : 8'h00;
        if (byte_valid_i && byte_ready_o) void'(feed_q.pop_front());
        prev_busy = busy_o;
        prev_err = error_o;
    end

    // Run-length watchdog.
    always @(posedge clk) begin
        if (cyc > LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic load_page(input int count);
        for (int i = 0; i < count; i++) begin
            item_t it;
            seed = seed * 32'd1103515245 + 32'd12345;
            it.off = i;
            it.data = int'(seed[23:16]);
            exp_q.push_back(it);
            feed_q.push_back(seed[23:16]);
        end
    endtask

    task automatic pulse_start(input int count, input int post);
        @(posedge clk); #2;
        start_i = 1'b1;
        start_count_i = 7'(count);
        post_delay_i = 8'(post);
        @(posedge clk); #2;
        start_i = 1'b0;
    endtask

    task automatic run_page(input int count, input int post);
        load_page(count);
        grants = 0;
        first_flag = 1'b1;
        cur_post = post;
        chk_post = 1'b1;
        pulse_start(count, post);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic flush();
        exp_q.delete();
        feed_q.delete();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bus_req_o && !byte_ready_o && !error_o, "R1 reset idle",
            int'(busy_o) + int'(bus_req_o) + int'(byte_ready_o) + int'(error_o), 0);

        // R1: counts 0 and 65 are rejected.
        pulse_start(0, 1);
        repeat (3) @(negedge clk);
        chk(!busy_o, "R1 count zero ignored", int'(busy_o), 0);
        pulse_start(65, 1);
        repeat (3) @(negedge clk);
        chk(!busy_o && !bus_req_o, "R1 count 65 ignored", int'(busy_o), 0);

        // R2/R3: short page with slow grants.
        gnt_delay = 2;
        run_page(4, 3);
        chk(busy_o, "R2 busy after start", int'(busy_o), 1);
        wait_idle();
        chk(exp_q.size() == 0, "R3 all bytes written", exp_q.size(), 0);
        chk(grants == 4, "R3 grant count", grants, 4);
        chk(!error_o, "R6 no error on paced page", int'(error_o), 0);

        // R3/R4: full 64-byte page, start while busy is ignored (R1).
        gnt_delay = 0;
        run_page(64, 1);
        repeat (500) @(negedge clk);
        pulse_start(5, 1);
        wait_idle();
        chk(grants == 64, "R1 R3 full page, busy start ignored", grants, 64);
        chk(exp_q.size() == 0, "R3 full page drained", exp_q.size(), 0);

        // R9: no request until a byte is supplied.
        feed_en = 1'b0;
        run_page(2, 1);
        repeat (40) @(negedge clk);
        chk(busy_o && byte_ready_o && !bus_req_o, "R9 waits for byte",
            int'(bus_req_o), 0);
        feed_en = 1'b1;
        wait_idle();
        chk(grants == 2, "R9 page completes after bytes", grants, 2);

        // R6: second grant withheld past the window.
        slow_from = 1;
        run_page(3, 1);
        wait_idle();
        chk(error_o, "R6 error raised", int'(error_o), 1);
        chk(grants == 1, "R6 only first byte written", grants, 1);
        chk_post = 1'b0;
        slow_from = 1000;
        flush();

        // R7: sticky error, rejected start keeps it, accepted start clears.
        repeat (100) @(negedge clk);
        chk(error_o, "R7 error held", int'(error_o), 1);
        pulse_start(0, 1);
        @(negedge clk);
        chk(error_o, "R7 rejected start keeps error", int'(error_o), 1);
        run_page(2, 1);
        chk(!error_o, "R7 accepted start clears error", int'(error_o), 0);
        wait_idle();
        chk(grants == 2, "R7 page after clear", grants, 2);

        // R8: abort mid-page.
        run_page(8, 2);
        for (int i = 0; i < 5000 && grants < 3; i++) @(negedge clk);
        chk_post = 1'b0;
        @(posedge clk); #2 abort_i = 1'b1;
        @(posedge clk); #2 abort_i = 1'b0;
        chk(!busy_o && !bus_req_o && !byte_ready_o && !error_o, "R8 abort to idle",
            int'(busy_o) + int'(bus_req_o) + int'(byte_ready_o) + int'(error_o), 0);
        flush();
        repeat (5) @(negedge clk);
        run_page(1, 1);
        wait_idle();
        chk(grants == 1 && exp_q.size() == 0, "R8 restart after abort", grants, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule